// File: doc/BRIEF.md
# MSI Vector Allocation Table

This block keeps track of the devices that have message-signalled interrupts switched on behind one host bridge. Each table slot holds a device configuration address, the number of vectors granted to that device, and the first system interrupt number of the contiguous block that was handed out for it. Interrupt numbers come from an allocator inside the block. The allocator only counts upward and never takes numbers back.

A command names a device by configuration address and is one of two kinds. A change command enables MSI or MSI-X with a requested vector count, or releases the device when the count is zero. A query command maps a device-relative vector index to a system interrupt number. Each command is accepted in a single cycle. The reply is registered and appears on the following cycle. It carries a status, the granted count, the caller's sequence number plus one, an interrupt type code, and for queries the interrupt number and a trigger flag.

The table is searched in slot order and the search stops at the first empty slot. Slots are filled in order, so a release in the middle of the table hides every slot behind it until the hole is filled again.

Top module: `msi_vec_table`

## Requirements
- R1: On a change command, function code 3 selects MSI and returns type 1, and function code 4 selects MSI-X and returns type 2. Any other function code returns status 8'hFD (parameter error) and leaves the table and the allocator unchanged.
- R2: Every command accepted with `cmd_valid` high produces `rsp_valid` high for exactly one cycle on the next clock edge. After reset, `rsp_valid` is 0 and all reply fields are 0.
- R3: An enable for an address that is not found claims the first empty slot and records the address, the count and a base interrupt. The first base after reset is `IRQ_FIRST`, and each later base equals the previous base plus the previous granted count.
- R4: An enable for an address that is found with the same nonzero count succeeds and keeps its existing base. The allocator does not advance.
- R5: An enable for an address that is found with a different nonzero count returns status 8'hFF and leaves the entry unchanged.
- R6: A change command with count 0 releases the device: the slot's count is cleared and status is 0. Releasing an address that is not found returns status 8'hFF.
- R7: The search runs in slot order and stops at the first slot whose count is zero. Entries behind a released slot are not found, and the next new enable reuses the released slot.
- R8: An enable for a new address when all `NUM_ENTRIES` slots are in use and none matches returns status 8'hFF.
- R9: If the requested block would run past interrupt number 2^16-1, the enable returns status 8'hFF and nothing is recorded.
- R10: A successful change command replies with status 0, `rsp_count` equal to the requested count, `rsp_seq` equal to `cmd_seq`+1 modulo 2^32, and the type code from R1. Every failed command replies with count, sequence, type, interrupt and trigger flag all 0.
- R11: A query for a found address returns status 0, `rsp_irq` = base + `cmd_vec` modulo 2^16, and `rsp_edge` = 1, with count, sequence and type 0. A query for an address that is not found returns status 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_query | input | 1 | 1 = query command, 0 = change command |
| cmd_func | input | 8 | Function code for a change command (3 MSI, 4 MSI-X) |
| cmd_cfg | input | 32 | Device configuration address |
| cmd_count | input | 16 | Requested vector count, 0 = release |
| cmd_seq | input | 32 | Caller sequence number |
| cmd_vec | input | 16 | Device vector index for a query |
| rsp_valid | output | 1 | Reply present |
| rsp_status | output | 8 | 0 ok, 8'hFF hardware error, 8'hFD parameter error |
| rsp_count | output | 16 | Granted vector count |
| rsp_seq | output | 32 | Sequence number plus one |
| rsp_type | output | 2 | 1 MSI, 2 MSI-X |
| rsp_irq | output | 16 | System interrupt number from a query |
| rsp_edge | output | 1 | 1 = edge-triggered (set on query success) |

## Verification
The bench releases a slot in the middle of the table and then queries an entry behind it. A design that scanned past empty slots would wrongly find that entry. It then checks that the next new enable lands in the hole and keeps the old base of a later re-enable, which catches designs that append at the end or reallocate on a matching count. It fills every slot to hit the full-table error. It asks for a block larger than the remaining number space to check that a failed allocation records nothing and does not move the allocator. It also sends a sequence number of all ones, where a wrong width or a missing increment shows up as a bad wrap. Random change and query traffic over a small address pool covers mismatched counts, bad function codes and repeated releases.

// File: rtl/msi_vec_pkg.sv
package msi_vec_pkg;
    localparam int CFG_W  = 32;
    localparam int CNT_W  = 16;
    localparam int IRQ_W  = 16;
    localparam int FUNC_W = 8;
    localparam int SEQ_W  = 32;

    localparam logic [FUNC_W-1:0] FN_MSI  = 8'd3;
    localparam logic [FUNC_W-1:0] FN_MSIX = 8'd4;

    localparam logic [7:0] ST_OK    = 8'h00;
    localparam logic [7:0] ST_HWERR = 8'hFF;
    localparam logic [7:0] ST_PARAM = 8'hFD;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_MSI  = 2'd1,
        KIND_MSIX = 2'd2
    } irq_kind_e;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [CNT_W-1:0] cnt;
        logic [IRQ_W-1:0] base;
    } slot_t;

    typedef struct packed {
        logic             valid;
        logic [7:0]       status;
        logic [CNT_W-1:0] count;
        logic [SEQ_W-1:0] seq;
        irq_kind_e        kind;
        logic [IRQ_W-1:0] irq;
        logic             edge_trig;
    } reply_t;

    function automatic irq_kind_e decode_func(input logic [FUNC_W-1:0] f);
        if (f == FN_MSI)  return KIND_MSI;
        if (f == FN_MSIX) return KIND_MSIX;
        return KIND_NONE;
    endfunction
endpackage

// File: rtl/msi_slot_store.sv
module msi_slot_store
    import msi_vec_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_slot,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output slot_t            slots [NUM_ENTRIES]
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                slots[g] <= wr_slot;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                slots[g].cnt <= '0;
            end
        end
    end

    // R6/R3: a slot is never written and cleared in the same cycle
    p_one_update_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && clr_en));

    // R3: a written slot holds the written count on the next cycle
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slots[$past(wr_idx)].cnt == $past(wr_slot.cnt));

    // R6: a cleared slot reads back with a zero count
    p_clear_lands_r6: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> slots[$past(clr_idx)].cnt == '0);
endmodule

// File: rtl/msi_slot_scan.sv
module msi_slot_scan
    import msi_vec_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  slot_t            slots [NUM_ENTRIES],
    input  logic [CFG_W-1:0] key,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             gap,
    output logic [IDX_W-1:0] gap_idx
);
    always_comb begin
        logic stop;
        stop    = 1'b0;
        hit     = 1'b0;
        gap     = 1'b0;
        hit_idx = '0;
        gap_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!stop) begin
                if (slots[i].cnt == '0) begin
                    gap     = 1'b1;
                    gap_idx = IDX_W'(i);
                    stop    = 1'b1;
                end else if (slots[i].cfg == key) begin
                    hit     = 1'b1;
                    hit_idx = IDX_W'(i);
                    stop    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/msi_irq_bump.sv
module msi_irq_bump
    import msi_vec_pkg::*;
#(
    parameter logic [IRQ_W-1:0] IRQ_FIRST = 16'h1000,
    localparam int SUM_W = ((CNT_W > IRQ_W) ? CNT_W : IRQ_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] req_cnt,
    input  logic             grant,
    output logic [IRQ_W-1:0] base,
    output logic             fits
);
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(1) << IRQ_W;

    logic [SUM_W-1:0] next_q;
    logic [SUM_W-1:0] sum;

    assign sum  = next_q + SUM_W'(req_cnt);
    assign fits = (sum <= LIMIT);
    assign base = next_q[IRQ_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= SUM_W'(IRQ_FIRST);
        end else if (grant) begin
            next_q <= sum;
        end
    end

    // R9: numbers are only handed out when the block fits
    p_grant_fits_r9: assert property (@(posedge clk) disable iff (rst)
        grant |-> fits);

    // R3: a grant always moves the allocator strictly forward
    p_bump_forward_r3: assert property (@(posedge clk) disable iff (rst)
        grant |=> next_q > $past(next_q));

    // R4: without a grant the allocator holds
    p_bump_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !grant |=> $stable(next_q));
endmodule

// File: rtl/msi_vec_table.sv
module msi_vec_table
    import msi_vec_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter logic [15:0] IRQ_FIRST = 16'h1000,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic        cmd_query,
    input  logic [7:0]  cmd_func,
    input  logic [31:0] cmd_cfg,
    input  logic [15:0] cmd_count,
    input  logic [31:0] cmd_seq,
    input  logic [15:0] cmd_vec,
    output logic        rsp_valid,
    output logic [7:0]  rsp_status,
    output logic [15:0] rsp_count,
    output logic [31:0] rsp_seq,
    output logic [1:0]  rsp_type,
    output logic [15:0] rsp_irq,
    output logic        rsp_edge
);
    slot_t            slots [NUM_ENTRIES];
    logic             hit, gap;
    logic [IDX_W-1:0] hit_idx, gap_idx;
    logic             wr_en, clr_en, grant, fits;
    slot_t            wr_slot;
    logic [IRQ_W-1:0] new_base;
    slot_t            hit_slot;
    irq_kind_e        kind;
    reply_t           nxt, cur;

    msi_slot_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(gap_idx), .wr_slot(wr_slot),
        .clr_en(clr_en), .clr_idx(hit_idx),
        .slots(slots)
    );

    msi_slot_scan #(.NUM_ENTRIES(NUM_ENTRIES)) u_scan (
        .slots(slots), .key(cmd_cfg),
        .hit(hit), .hit_idx(hit_idx), .gap(gap), .gap_idx(gap_idx)
    );

    msi_irq_bump #(.IRQ_FIRST(IRQ_FIRST)) u_bump (
        .clk(clk), .rst(rst),
        .req_cnt(cmd_count), .grant(grant),
        .base(new_base), .fits(fits)
    );

    assign hit_slot = slots[hit_idx];
    assign kind     = decode_func(cmd_func);

    always_comb begin
        wr_en   = 1'b0;
        clr_en  = 1'b0;
        grant   = 1'b0;
        wr_slot = '{cfg: cmd_cfg, cnt: cmd_count, base: new_base};
        nxt        = '0;
        nxt.valid  = cmd_valid;
        nxt.status = ST_HWERR;
        if (cmd_valid) begin
            if (cmd_query) begin
                if (hit) begin
                    nxt.status    = ST_OK;
                    nxt.irq       = hit_slot.base + cmd_vec;
                    nxt.edge_trig = 1'b1;
                end
            end else if (kind == KIND_NONE) begin
                nxt.status = ST_PARAM;
            end else if (cmd_count == '0) begin
                if (hit) begin
                    clr_en     = 1'b1;
                    nxt.status = ST_OK;
                end
            end else if (hit) begin
                if (hit_slot.cnt == cmd_count) begin
                    nxt.status = ST_OK;
                end
            end else if (gap && fits) begin
                wr_en      = 1'b1;
                grant      = 1'b1;
                nxt.status = ST_OK;
            end
            if (!cmd_query && nxt.status == ST_OK) begin
                nxt.count = cmd_count;
                nxt.seq   = cmd_seq + 32'd1;
                nxt.kind  = kind;
            end
        end else begin
            nxt.status = ST_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign rsp_valid  = cur.valid;
    assign rsp_status = cur.valid ? cur.status : ST_OK;
    assign rsp_count  = cur.count;
    assign rsp_seq    = cur.seq;
    assign rsp_type   = cur.kind;
    assign rsp_irq    = cur.irq;
    assign rsp_edge   = cur.edge_trig;

    // R2: one reply per accepted command, on the next edge
    p_reply_follows_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid);

    // R1: unknown function code on a change command is a parameter error
    p_bad_func_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_query && cmd_func != 8'd3 && cmd_func != 8'd4)
        |=> rsp_status == 8'hFD);

    // R10: a successful change reply carries the incremented sequence
    p_seq_step_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_query) |=>
        (rsp_status != 8'h00 || rsp_seq == $past(cmd_seq) + 32'd1));

    // R11: the trigger flag only accompanies a successful reply
    p_edge_ok_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_edge |-> (rsp_valid && rsp_status == 8'h00 && rsp_type == 2'd0));
endmodule

// File: tb/msi_vec_table_tb.sv
module msi_vec_table_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam logic [15:0] FIRST = 16'h1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_query = 1'b0;
    logic [7:0]  cmd_func = '0;
    logic [31:0] cmd_cfg = '0, cmd_seq = '0;
    logic [15:0] cmd_count = '0, cmd_vec = '0;
    logic        rsp_valid, rsp_edge;
    logic [7:0]  rsp_status;
    logic [15:0] rsp_count, rsp_irq;
    logic [31:0] rsp_seq;
    logic [1:0]  rsp_type;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [31:0] m_cfg [N];
    logic [15:0] m_cnt [N];
    logic [15:0] m_base [N];
    int          m_next;

    // expected reply
    logic [7:0]  e_status;
    logic [15:0] e_count, e_irq;
    logic [31:0] e_seq;
    logic [1:0]  e_type;
    logic        e_edge;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_vec_table #(.NUM_ENTRIES(N), .IRQ_FIRST(FIRST)) u_dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_query(cmd_query), .cmd_func(cmd_func),
        .cmd_cfg(cmd_cfg), .cmd_count(cmd_count), .cmd_seq(cmd_seq),
        .cmd_vec(cmd_vec),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_count(rsp_count),
        .rsp_seq(rsp_seq), .rsp_type(rsp_type), .rsp_irq(rsp_irq),
        .rsp_edge(rsp_edge)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_cfg[i] = '0; m_cnt[i] = '0; m_base[i] = '0;
        end
        m_next = FIRST;
    endtask

    // expected reply computed from the requirements
    task automatic model_step(input logic q, input logic [7:0] f, input logic [31:0] a,
                              input logic [15:0] c, input logic [31:0] s,
                              input logic [15:0] v);
        int hi, gi;
        hi = -1; gi = -1;
        for (int i = 0; i < N; i++) begin
            if (hi < 0 && gi < 0) begin
                if (m_cnt[i] == 0) gi = i;
                else if (m_cfg[i] == a) hi = i;
            end
        end
        e_status = 8'hFF; e_count = 0; e_seq = 0; e_type = 0; e_irq = 0; e_edge = 0;
        if (q) begin
            if (hi >= 0) begin
                e_status = 8'h00; e_irq = m_base[hi] + v; e_edge = 1'b1;
            end
        end else if (f != 8'd3 && f != 8'd4) begin
            e_status = 8'hFD;
        end else begin
            if (c == 0) begin
                if (hi >= 0) begin m_cnt[hi] = 0; e_status = 8'h00; end
            end else if (hi >= 0) begin
                if (m_cnt[hi] == c) e_status = 8'h00;
            end else if (gi >= 0 && (m_next + int'(c)) <= 65536) begin
                m_cfg[gi] = a; m_cnt[gi] = c; m_base[gi] = 16'(m_next);
                m_next = m_next + int'(c);
                e_status = 8'h00;
            end
            if (e_status == 8'h00) begin
                e_count = c; e_seq = s + 32'd1; e_type = (f == 8'd4) ? 2'd2 : 2'd1;
            end
        end
    endtask

    task automatic do_cmd(input logic q, input logic [7:0] f, input logic [31:0] a,
                          input logic [15:0] c, input logic [31:0] s,
                          input logic [15:0] v, input string tag);
        model_step(q, f, a, c, s, v);
        cmd_valid = 1'b1; cmd_query = q; cmd_func = f; cmd_cfg = a;
        cmd_count = c; cmd_seq = s; cmd_vec = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({"R2 valid ", tag}, 64'(rsp_valid), 64'd1);
        check({tag, " status"}, 64'(rsp_status), 64'(e_status));
        check({tag, " count"},  64'(rsp_count),  64'(e_count));
        check({tag, " seq"},    64'(rsp_seq),    64'(e_seq));
        check({tag, " type"},   64'(rsp_type),   64'(e_type));
        check({tag, " irq"},    64'(rsp_irq),    64'(e_irq));
        check({tag, " edge"},   64'(rsp_edge),   64'(e_edge));
    endtask

    task automatic do_reset();
        rst = 1'b1; cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        check("R2 reset valid",  64'(rsp_valid),  64'd0);
        check("R2 reset status", 64'(rsp_status), 64'd0);
        check("R2 reset irq",    64'(rsp_irq),    64'd0);

        // R1 / R3 / R10: first allocations and type codes
        do_cmd(0, 8'd3, 32'hA0, 16'd2, 32'd7, 0, "R3 first base MSI");
        do_cmd(0, 8'd4, 32'hB0, 16'd3, 32'd9, 0, "R1 MSIX type");
        do_cmd(0, 8'd3, 32'hC0, 16'd1, 32'hFFFF_FFFF, 0, "R10 seq wrap");
        do_cmd(0, 8'd5, 32'hD0, 16'd1, 32'd1, 0, "R1 bad func");
        do_cmd(1, 8'd0, 32'hD0, 16'd0, 32'd0, 0, "R1 bad func no entry");
        do_cmd(1, 8'd0, 32'hB0, 16'd0, 32'd0, 16'd2, "R11 query B");
        @(negedge clk);
        check("R2 idle valid", 64'(rsp_valid), 64'd0);
        // R6 / R7: hole in the middle
        do_cmd(0, 8'd4, 32'hB0, 16'd0, 32'd3, 0, "R6 release B");
        do_cmd(0, 8'd4, 32'hB0, 16'd0, 32'd4, 0, "R6 release missing");
        do_cmd(1, 8'd0, 32'hC0, 16'd0, 32'd0, 0, "R7 query behind hole");
        do_cmd(0, 8'd3, 32'hE0, 16'd2, 32'd5, 0, "R7 fill hole");
        do_cmd(1, 8'd0, 32'hE0, 16'd0, 32'd0, 16'd1, "R7 query reused slot");
        do_cmd(0, 8'd3, 32'hC0, 16'd1, 32'd6, 0, "R4 same count keeps base");
        do_cmd(1, 8'd0, 32'hC0, 16'd0, 32'd0, 16'd0, "R4 base kept");
        do_cmd(0, 8'd3, 32'hA0, 16'd5, 32'd8, 0, "R5 count mismatch");
        do_cmd(1, 8'd0, 32'hA0, 16'd0, 32'd0, 16'd1, "R5 entry unchanged");
        do_cmd(1, 8'd0, 32'hF0, 16'd0, 32'd0, 0, "R11 query unknown");

        // random mix on a small address pool
        for (int k = 0; k < 400; k++) begin
            logic        q;
            logic [7:0]  f;
            logic [31:0] a;
            q = ($urandom % 4) == 0;
            case ($urandom % 5)
                0, 1: f = 8'd3;
                2, 3: f = 8'd4;
                default: f = 8'($urandom % 8);
            endcase
            a = 32'h100 + 32'(($urandom % 6) * 8);
            do_cmd(q, f, a, 16'($urandom % 5), $urandom, 16'($urandom % 8), "R10 random");
        end

        // R8 / R9: full table and number exhaustion
        do_reset();
        for (int i = 0; i < N; i++)
            do_cmd(0, 8'd3, 32'h1000 + 32'(i), 16'd1, 32'(i), 0, "R3 fill table");
        do_cmd(0, 8'd3, 32'h2000, 16'd1, 32'd0, 0, "R8 table full");
        do_cmd(0, 8'd3, 32'h1000 + 32'(N-1), 16'd0, 32'd0, 0, "R6 release last");
        do_cmd(0, 8'd4, 32'h3000, 16'hFFFF, 32'd0, 0, "R9 exhaustion");
        do_cmd(1, 8'd0, 32'h3000, 16'd0, 32'd0, 0, "R9 nothing recorded");
        do_cmd(0, 8'd4, 32'h3000, 16'd1, 32'd0, 0, "R3 base after failure");
        do_cmd(1, 8'd0, 32'h3000, 16'd0, 32'd0, 16'hFFFF, "R11 irq wrap");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule